// File: doc/BRIEF.md
# SPI Interrupt and Status Generator

This block produces the single interrupt request line of an SPI controller and the sticky status flags that software reads to find out why the line went high. It sits beside the shift engine and the two FIFOs. It sees a strobe for each of these events: a byte leaving the transmit FIFO for the shift register, a byte entering the receive FIFO, a transfer starting, and a status-register read or control-register write. It also sees the receive FIFO occupancy and full indication. From these it keeps four sources: transmit-count, receive-level, underrun and overflow.

A mode input picks whether the data interrupt follows the transmit side or the receive side. A 3-bit threshold N sets how many bytes make up one event. On the transmit side, a counter of transmitted bytes fires on every (N+1)-th byte. On the receive side, the FIFO occupancy is compared with N+1 only at the instant a byte is written. Underrun and overflow are raised without regard to the threshold. Each side has a mask input that suppresses both its data interrupt and its error source. The FIFO flushes, the enable input and a status read clear the flags. Any other change of configuration leaves pending flags untouched.

Top module: `spi_irq_status`

## Requirements
- R1: After reset, `irq` is 0 and every `status` bit is 0.
- R2: With `en`=1 and `tx_mode`=1, the transmit flag (`status[1]`) sets after every `thresh`+1 cycles with `tx_pop` high. It is visible in the cycle after the pop that completes the group.
- R3: A cycle with `ctl_wr` high returns the transmitted-byte count to zero, and a `tx_pop` in that same cycle is not counted. With `thresh`=3, three pops, a control write and then three more pops, the flag stays clear, and it sets on the fourth pop after the write.
- R4: With `tx_mode`=0, a `rx_push` while `rx_full`=0 sets the receive flag (`status[2]`) when `rx_level` (the occupancy including the byte being written) is at least `thresh`+1. Otherwise it leaves the flag unchanged.
- R5: Once a status read has cleared the receive flag, it stays clear until another `rx_push` meets the R4 condition, however long the FIFO stays full enough.
- R6: `xfer_start` together with `tx_empty` sets the underrun flag (`status[3]`), whatever the mode and threshold, unless `tx_mask` is 1.
- R7: `rx_push` together with `rx_full` sets the overflow flag (`status[4]`), whatever the mode and threshold, unless `rx_mask` is 1. Such a push never sets the receive flag.
- R8: `tx_mask`=1 blocks the transmit flag and `rx_mask`=1 blocks the receive flag. The data source not chosen by `tx_mode` never sets.
- R9: A cycle with `stat_rd` high clears all four flags from the next cycle on. An event in the same cycle still sets its flag.
- R10: While `en` is 0 all flags read 0, events are ignored, and the transmitted-byte count is held at zero.
- R11: `tx_flush` clears only the transmit flag and `rx_flush` clears only the receive flag, and each wins over a coincident event of its own source. Changing `tx_mode`, `thresh` or the masks leaves pending flags set.
- R12: `status[0]` equals `irq`, and `irq` equals the OR of `status[4:1]` in every cycle. The bit layout is 0 line, 1 transmit, 2 receive, 3 underrun, 4 overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | SPI enable; low clears flags and count |
| tx_mode | input | 1 | 1 selects the transmit data interrupt, 0 the receive one |
| thresh | input | THR_W | Threshold N; events every N+1 bytes |
| tx_mask | input | 1 | Suppresses transmit and underrun sources |
| rx_mask | input | 1 | Suppresses receive and overflow sources |
| tx_flush | input | 1 | Transmit FIFO flush; clears transmit flag |
| rx_flush | input | 1 | Receive FIFO flush; clears receive flag |
| ctl_wr | input | 1 | Control-register write strobe |
| stat_rd | input | 1 | Status-register read strobe |
| tx_pop | input | 1 | Byte moved from transmit FIFO to shift register |
| rx_push | input | 1 | Byte arriving for the receive FIFO |
| xfer_start | input | 1 | Transfer start strobe |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_level | input | LVL_W | Receive occupancy including a byte pushed this cycle |
| irq | output | 1 | Registered interrupt line |
| status | output | 5 | Flags: line, transmit, receive, underrun, overflow |

## Verification
A wrong transmitted-byte count does not show at once. It appears only at the next group boundary, as a transmit flag one or more pops early or late. The bench therefore runs pop sequences across control writes, disables and coincident strobes, so that a stale count shows within a few cycles. A flag held wrongly, or a wrong clear priority, shows in `status` in the very next cycle. A mismatch between the line and the sources shows in the same cycle as `status[0]`. A behavioural model compared on every clock catches both.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int ST_W   = 5;
   localparam int ST_IRQ = 0;
   localparam int N_SRC  = 4;

   typedef enum int {
      SRC_TX  = 0,
      SRC_RX  = 1,
      SRC_UDR = 2,
      SRC_OVF = 3
   } src_e;

   // status bit of a source: line bit sits below the four sources
   function automatic int src_bit(src_e s);
      return int'(s) + 1;
   endfunction
endpackage

// File: rtl/spi_irq_flag.sv
module spi_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic kill,
   output logic d,
   output logic q
);
   // kill (disable or flush) beats set; set beats a read clear
   always_comb begin
      if (kill)      d = 1'b0;
      else if (set)  d = 1'b1;
      else if (clr)  d = 1'b0;
      else           d = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

   // R11 / R10: a hard clear always leaves the flag low
   assert_kill_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !q);
   // R9: a set never gets lost unless killed
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !kill) |=> q);
endmodule

// File: rtl/spi_irq_txcnt.sv
module spi_irq_txcnt #(
   parameter int THR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             step,
   input  logic [THR_W-1:0] thresh,
   output logic             fire
);
   logic [THR_W-1:0] cnt_q;
   logic             at_limit;

   initial begin
      assert_thr_w_ok: assert (THR_W >= 1 && THR_W <= 16)
         else $error("THR_W out of range");
   end

   always_comb begin
      at_limit = (cnt_q == thresh);
      fire     = en && step && !clr && at_limit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en || clr)     cnt_q <= '0;
      else if (step) begin
         if (at_limit)         cnt_q <= '0;
         else                  cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: after a control write the count starts from zero
   assert_ctl_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr) |=> (cnt_q == '0));
   // R10: disabled means count held at zero
   assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));
   // R2: no firing without a counted byte
   assert_fire_needs_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (step && en));
endmodule

// File: rtl/spi_irq_rxcmp.sv
module spi_irq_rxcmp #(
   parameter int THR_W            = 3,
   parameter int LVL_W            = 4,
   parameter bit LEVEL_AFTER_PUSH = 1'b1
) (
   input  logic             en,
   input  logic             push,
   input  logic             full,
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thresh,
   output logic             fire
);
   localparam int CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

   logic [CMP_W-1:0] occ;
   logic [CMP_W-1:0] need;

   initial begin
      assert_lvl_w_ok: assert (LVL_W >= 1 && LVL_W <= 16)
         else $error("LVL_W out of range");
   end

   generate
      if (LEVEL_AFTER_PUSH) begin : g_post
         always_comb occ = CMP_W'(level);
      end else begin : g_pre
         always_comb occ = CMP_W'(level) + CMP_W'(1);
      end
   endgenerate

   always_comb begin
      need = CMP_W'(thresh) + CMP_W'(1);
      fire = en && push && !full && (occ >= need);
   end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
   import spi_irq_pkg::*;
#(
   parameter int THR_W            = 3,
   parameter int LVL_W            = 4,
   parameter bit LEVEL_AFTER_PUSH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tx_mode,
   input  logic [THR_W-1:0] thresh,
   input  logic             tx_mask,
   input  logic             rx_mask,
   input  logic             tx_flush,
   input  logic             rx_flush,
   input  logic             ctl_wr,
   input  logic             stat_rd,
   input  logic             tx_pop,
   input  logic             rx_push,
   input  logic             xfer_start,
   input  logic             tx_empty,
   input  logic             rx_full,
   input  logic [LVL_W-1:0] rx_level,
   output logic             irq,
   output logic [ST_W-1:0]  status
);
   logic             tx_fire;
   logic             rx_fire;
   logic [N_SRC-1:0] src_set;
   logic [N_SRC-1:0] src_kill;
   logic [N_SRC-1:0] src_d;
   logic [N_SRC-1:0] src_q;
   logic             irq_q;

   spi_irq_txcnt #(.THR_W(THR_W)) u_txcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .clr    (ctl_wr),
      .step   (tx_pop),
      .thresh (thresh),
      .fire   (tx_fire)
   );

   spi_irq_rxcmp #(
      .THR_W            (THR_W),
      .LVL_W            (LVL_W),
      .LEVEL_AFTER_PUSH (LEVEL_AFTER_PUSH)
   ) u_rxcmp (
      .en     (en),
      .push   (rx_push),
      .full   (rx_full),
      .level  (rx_level),
      .thresh (thresh),
      .fire   (rx_fire)
   );

   always_comb begin
      src_set[SRC_TX]   = tx_fire && tx_mode && !tx_mask;
      src_set[SRC_RX]   = rx_fire && !tx_mode && !rx_mask;
      src_set[SRC_UDR]  = en && xfer_start && tx_empty && !tx_mask;
      src_set[SRC_OVF]  = en && rx_push && rx_full && !rx_mask;
      src_kill[SRC_TX]  = !en || tx_flush;
      src_kill[SRC_RX]  = !en || rx_flush;
      src_kill[SRC_UDR] = !en;
      src_kill[SRC_OVF] = !en;
   end

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         spi_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (src_set[i]),
            .clr   (stat_rd),
            .kill  (src_kill[i]),
            .d     (src_d[i]),
            .q     (src_q[i])
         );
      end
   endgenerate

   // line registered from the same next-state as the flags: no glitches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |src_d;
   end

   always_comb begin
      irq                        = irq_q;
      status[ST_IRQ]             = irq_q;
      status[src_bit(SRC_TX)]    = src_q[SRC_TX];
      status[src_bit(SRC_RX)]    = src_q[SRC_RX];
      status[src_bit(SRC_UDR)]   = src_q[SRC_UDR];
      status[src_bit(SRC_OVF)]   = src_q[SRC_OVF];
   end

   assert_line_or_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|src_q));
   assert_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && xfer_start && tx_empty && !tx_mask) |=> status[src_bit(SRC_UDR)]);
   assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rx_push && rx_full && !rx_mask) |=> status[src_bit(SRC_OVF)]);
   assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tx_pop && !rx_push && !xfer_start) |=> (status == '0));
   assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (status == '0 && !irq));
   assert_rx_needs_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[src_bit(SRC_RX)]) |-> $past(rx_push));
   assert_rx_full_no_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && stat_rd) |=> !status[src_bit(SRC_RX)]);
endmodule

// File: tb/tb_spi_irq_status.sv
module tb_spi_irq_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 0, tx_mode = 0, tx_mask = 0, rx_mask = 0;
   logic       tx_flush = 0, rx_flush = 0, ctl_wr = 0, stat_rd = 0;
   logic       tx_pop = 0, rx_push = 0, xfer_start = 0, tx_empty = 0, rx_full = 0;
   logic [2:0] thresh = '0;
   logic [3:0] rx_level = '0;
   logic       irq;
   logic [4:0] status;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   localparam logic [4:0] TXB = 5'b00011;
   localparam logic [4:0] RXB = 5'b00101;
   localparam logic [4:0] UDB = 5'b01001;
   localparam logic [4:0] OVB = 5'b10001;

   always #4 clk = ~clk;   // 125 MHz

   spi_irq_status dut (
      .clk(clk), .rst_n(rst_n), .en(en), .tx_mode(tx_mode), .thresh(thresh),
      .tx_mask(tx_mask), .rx_mask(rx_mask), .tx_flush(tx_flush), .rx_flush(rx_flush),
      .ctl_wr(ctl_wr), .stat_rd(stat_rd), .tx_pop(tx_pop), .rx_push(rx_push),
      .xfer_start(xfer_start), .tx_empty(tx_empty), .rx_full(rx_full),
      .rx_level(rx_level), .irq(irq), .status(status)
   );

   // behavioural reference model
   int   m_cnt = 0;
   bit   m_tx = 0, m_rx = 0, m_ud = 0, m_ov = 0;

   always @(posedge clk) begin
      bit ftx, frx, fu, fo;
      if (!rst_n) begin
         m_cnt = 0; m_tx = 0; m_rx = 0; m_ud = 0; m_ov = 0;
      end else begin
         ftx = 0;
         if (!en || ctl_wr) m_cnt = 0;
         else if (tx_pop) begin
            if (m_cnt == int'(thresh)) begin ftx = 1; m_cnt = 0; end
            else m_cnt = (m_cnt + 1) % 8;
         end
         frx = en && rx_push && !rx_full && (int'(rx_level) > int'(thresh));
         ftx = ftx && tx_mode && !tx_mask;
         frx = frx && !tx_mode && !rx_mask;
         fu  = en && xfer_start && tx_empty && !tx_mask;
         fo  = en && rx_push && rx_full && !rx_mask;
         if (stat_rd) begin m_tx = 0; m_rx = 0; m_ud = 0; m_ov = 0; end
         if (ftx) m_tx = 1;
         if (frx) m_rx = 1;
         if (fu)  m_ud = 1;
         if (fo)  m_ov = 1;
         if (tx_flush) m_tx = 0;
         if (rx_flush) m_rx = 0;
         if (!en) begin m_tx = 0; m_rx = 0; m_ud = 0; m_ov = 0; end
      end
   end

   function automatic logic [4:0] model_status();
      bit any;
      any = m_tx || m_rx || m_ud || m_ov;
      return {m_ov, m_ud, m_rx, m_tx, any};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
         finish_run();
      end
   end

   // one clock; on return outputs of that clock are settled (negedge)
   task automatic step();
      @(negedge clk);
      checks++;
      if (status !== model_status() || irq !== status[0] || irq !== |status[4:1]) begin
         fails++;
         $display("FAIL R12 per-cycle model: actual status=%b irq=%b expected status=%b",
                  status, irq, model_status());
      end
   endtask

   task automatic chk(string req, logic [4:0] exp);
      checks++;
      if (status !== exp || irq !== exp[0]) begin
         fails++;
         $display("FAIL %s: actual status=%b irq=%b expected status=%b", req, status, irq, exp);
      end
   endtask

   task automatic pop(int n);
      tx_pop = 1; repeat (n) step(); tx_pop = 0;
   endtask
   task automatic push(logic [3:0] lvl);
      rx_level = lvl; rx_push = 1; step(); rx_push = 0;
   endtask
   task automatic rd();
      stat_rd = 1; step(); stat_rd = 0;
   endtask
   task automatic ctl();
      ctl_wr = 1; step(); ctl_wr = 0;
   endtask
   task automatic start(logic empty);
      xfer_start = 1; tx_empty = empty; step(); xfer_start = 0; tx_empty = 0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1; step();
      chk("R1 reset", 5'b0);

      en = 1; tx_mode = 1; thresh = 3'd2; step();
      pop(2);  chk("R2 two of three", 5'b0);
      pop(1);  chk("R2 group done", TXB);
      rd();    chk("R9 read clears", 5'b0);

      thresh = 3'd3; ctl();
      pop(3); ctl(); pop(3); chk("R3 restart after write", 5'b0);
      pop(1); chk("R3 fourth after write", TXB);
      rd();
      pop(3); ctl_wr = 1; tx_pop = 1; step(); ctl_wr = 0; tx_pop = 0;
      pop(3); chk("R3 coincident pop not counted", 5'b0);
      pop(1); chk("R3 coincident then fourth", TXB);
      rd();

      tx_mode = 0; thresh = 3'd1; step();
      push(4'd1); chk("R4 below level", 5'b0);
      push(4'd2); chk("R4 at level", RXB);
      rd();       chk("R5 cleared", 5'b0);
      rx_level = 4'd2; repeat (3) step();
      chk("R5 no regeneration without push", 5'b0);
      push(4'd3); chk("R5 new push", RXB);
      rd();

      rx_mask = 1; push(4'd5); chk("R8 rx mask", 5'b0); rx_mask = 0;
      thresh = 3'd0; pop(4); chk("R8 tx source unselected", 5'b0);
      tx_mode = 1; tx_mask = 1; pop(2); chk("R8 tx mask", 5'b0);
      tx_mask = 0; tx_mode = 0; step();

      start(1); chk("R6 underrun", UDB);
      rd();
      tx_mask = 1; start(1); chk("R6 masked", 5'b0); tx_mask = 0;
      start(0); chk("R6 not empty", 5'b0);

      rx_full = 1; push(4'd8); chk("R7 overflow, no rx flag", OVB);
      rd();
      rx_mask = 1; push(4'd8); chk("R7 masked", 5'b0);
      rx_mask = 0; rx_full = 0; step();

      stat_rd = 1; start(1); stat_rd = 0; chk("R9 event beats read", UDB);

      push(4'd4); chk("R11 rx and underrun pending", 5'b01101);
      thresh = 3'd5; tx_mode = 1; rx_mask = 1; tx_mask = 1; step();
      chk("R11 reconfigure keeps flags", 5'b01101);
      rx_flush = 1; step(); rx_flush = 0; chk("R11 rx flush", UDB);
      tx_mask = 0; rx_mask = 0; tx_mode = 0; thresh = 3'd0;
      rx_flush = 1; push(4'd4); rx_flush = 0; chk("R11 flush beats push", UDB);
      tx_mode = 1; ctl(); pop(1); chk("R11 tx pending", 5'b01011);
      tx_flush = 1; step(); tx_flush = 0; chk("R11 tx flush", UDB);

      en = 0; step(); chk("R10 disable clears", 5'b0);
      start(1); rx_full = 1; push(4'd8); rx_full = 0; pop(2);
      chk("R10 events ignored", 5'b0);
      en = 1; thresh = 3'd1; ctl();
      pop(1); en = 0; step(); en = 1;
      pop(1); chk("R10 count held at zero", 5'b0);
      pop(1); chk("R10 group after re-enable", TXB);
      rd(); chk("R12 idle", 5'b0);

      repeat (2) step();
      finish_run();
   end
endmodule